// File: doc/BRIEF.md
# Instruction-Driven Nonvolatile Image Sequencer

This block copies chosen parts of an on-chip register map into an external byte-wide nonvolatile memory, and it can later put that image back into the register map. The copy is driven by a short instruction list held in the register map at a fixed base offset. Each instruction byte is copied to the memory image as it is read. A data instruction with value N (0x00 to 0x7F) is followed by a two-byte source address, high byte first, and copies N+1 consecutive register bytes. After those bytes the block writes one checksum byte. Code 0x80 marks an update point. Code 0xFF ends the list.

Software first sets the write-enable bit and an optional 4-bit condition value through a small control port. It then pulses save or load. During a save the block reads the list and the register map through the map port and writes bytes to memory locations 0, 1, 2 and so on through a request/acknowledge handshake. During a load it reads the image back from location 0. Each run is held in a local buffer until its checksum has been verified, and only then is it written into the map. Each update point raises a one-cycle pulse. `busy` is high while a sequence runs, and `done` pulses once when the sequence ends.

Top module: `nvm_image_seq`

## Requirements
- R1: After reset, write-enable is 0 (protected) and the condition value is 0. `busy`, `done`, `cks_err`, `upd_pulse`, `mem_req` and `rm_wr` are all low.
- R2: A save pulse while write-enable is 0 is ignored: `busy` stays low and no memory write takes place.
- R3: A data instruction N (bit 7 clear) writes the following bytes to consecutive memory locations: the instruction byte, the address high byte, the address low byte, then N+1 bytes read from consecutive register addresses starting at that address, then a checksum. The image starts at memory location 0.
- R4: The checksum byte is the 8-bit two's complement of the sum of the run's data bytes, so data plus checksum equals 0 modulo 256.
- R5: Code 0x80 is stored as one byte. Code 0xFF is stored and ends the sequence, with `done` high for exactly one cycle and `busy` low from that cycle on.
- R6: During a save, codes 0x81 to 0xFE are skipped and not written to memory.
- R7: A load rewrites each data run found in the image into the register map, starting at the run's stored address.
- R8: During a load, each 0x80 in the image gives exactly one cycle of `upd_pulse`.
- R9: During a load, a run whose checksum does not match sets the sticky `cks_err` and is not written to the map. Later runs are still applied. `cks_err` clears when the next load starts.
- R10: With condition value K nonzero, a load applies only the first K data runs of the image. With K = 0 it applies all runs.
- R11: A memory request holds its address, data and direction until it is acknowledged. Save and load pulses are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Strobe that loads the control fields below |
| ctl_wen | input | 1 | Write-enable value (1 allows saves) |
| ctl_cond | input | 4 | Condition value for loads |
| save_go | input | 1 | Pulse that starts a save |
| load_go | input | 1 | Pulse that starts a load |
| rm_rd | output | 1 | Register-map read strobe (data returns next cycle) |
| rm_wr | output | 1 | Register-map write strobe |
| rm_addr | output | 16 | Register-map address |
| rm_wdata | output | 8 | Register-map write data |
| rm_rdata | input | 8 | Register-map read data, valid the cycle after `rm_rd` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MAW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| busy | output | 1 | A save or load is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| upd_pulse | output | 1 | One-cycle pulse per update point during a load |
| cks_err | output | 1 | Sticky checksum-mismatch flag |

## Verification
The bench covers these corner cases:
- The shortest run (one byte) and the longest run (128 bytes). A counter that is off by one would write a byte too many or too few, and every later location in the image would be shifted.
- Skipped codes mixed into the list. A design that stored them would shift the image.
- A corrupted checksum byte. A design that applied the run before checking it would overwrite the sentinel values that the bench expects to survive.
- A sweep of condition values, including values larger than the number of runs. An off-by-one in the gating compare would drop or add a run.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  localparam int RM_AW   = 16;
  localparam int LEN_W   = 7;
  localparam int RUN_MAX = 1 << LEN_W;

  localparam logic [7:0] OP_UPDATE = 8'h80;
  localparam logic [7:0] OP_END    = 8'hFF;

  typedef enum logic [2:0] {
    PH_OP,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_CKS
  } phase_t;

  function automatic logic is_data_op(input logic [7:0] b);
    return !b[7];
  endfunction

  function automatic logic is_kept_op(input logic [7:0] b);
    return is_data_op(b) || (b == OP_UPDATE) || (b == OP_END);
  endfunction

  function automatic logic [7:0] sum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  function automatic logic [7:0] cks_of(input logic [7:0] sum);
    return ~sum + 8'd1;
  endfunction

  function automatic logic cks_good(input logic [7:0] sum, input logic [7:0] c);
    logic [7:0] t;
    t = sum + c;
    return t == 8'h00;
  endfunction

  function automatic logic run_allowed(input logic [3:0] cond, input logic [3:0] run_no);
    return (cond == 4'd0) || (run_no < cond);
  endfunction

endpackage

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_wen,
  input  logic [3:0] ctl_cond,
  input  logic       save_go,
  input  logic       load_go,
  input  logic       busy,
  output logic       wen_q,
  output logic [3:0] cond_q,
  output logic       start_save,
  output logic       start_load
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      cond_q <= 4'd0;
    end else if (ctl_wr) begin
      wen_q  <= ctl_wen;
      cond_q <= ctl_cond;
    end
  end

  always_comb begin
    start_save = save_go && wen_q && !busy;
    start_load = load_go && !busy && !start_save;
  end

endmodule

// File: rtl/nvm_seq_save.sv
module nvm_seq_save
  import nvm_seq_pkg::*;
#(
  parameter int         MAW       = 12,
  parameter logic [15:0] LIST_BASE = 16'h0E10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rm_rd,
  output logic [RM_AW-1:0] rm_addr,
  input  logic [7:0]       rm_rdata,
  output logic             mem_req,
  output logic [MAW-1:0]   mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  output logic             active,
  output logic             fin
);

  typedef enum logic [1:0] {SV_IDLE, SV_FETCH, SV_CAPT, SV_MWR} sv_st_t;

  sv_st_t           st;
  phase_t           ph;
  logic [RM_AW-1:0] ip;
  logic [RM_AW-1:0] src;
  logic [MAW-1:0]   ptr;
  logic [7:0]       op;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       sum;
  logic [7:0]       byte_q;
  logic             fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SV_IDLE;
      ph     <= PH_OP;
      ip     <= '0;
      src    <= '0;
      ptr    <= '0;
      op     <= '0;
      cnt    <= '0;
      sum    <= '0;
      byte_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st)
        SV_IDLE: begin
          if (start) begin
            ip  <= LIST_BASE;
            ptr <= '0;
            ph  <= PH_OP;
            st  <= SV_FETCH;
          end
        end
        SV_FETCH: st <= SV_CAPT;
        SV_CAPT: begin
          byte_q <= rm_rdata;
          st     <= SV_MWR;
          case (ph)
            PH_OP: begin
              op <= rm_rdata;
              if (!is_kept_op(rm_rdata)) begin
                ip <= ip + 1'b1;
                st <= SV_FETCH;
              end
            end
            PH_AHI:  src <= {rm_rdata, src[7:0]};
            PH_ALO:  src <= {src[15:8], rm_rdata};
            PH_DATA: sum <= sum_add(sum, rm_rdata);
            default: ;
          endcase
        end
        SV_MWR: begin
          if (mem_ack) begin
            ptr <= ptr + 1'b1;
            st  <= SV_FETCH;
            case (ph)
              PH_OP: begin
                if (op == OP_END) begin
                  st    <= SV_IDLE;
                  fin_q <= 1'b1;
                end else if (op == OP_UPDATE) begin
                  ip <= ip + 1'b1;
                end else begin
                  ip <= ip + 1'b1;
                  ph <= PH_AHI;
                end
              end
              PH_AHI: begin
                ip <= ip + 1'b1;
                ph <= PH_ALO;
              end
              PH_ALO: begin
                ip  <= ip + 1'b1;
                ph  <= PH_DATA;
                cnt <= op[LEN_W-1:0];
                sum <= 8'd0;
              end
              PH_DATA: begin
                src <= src + 1'b1;
                if (cnt == '0) begin
                  ph     <= PH_CKS;
                  byte_q <= cks_of(sum);
                  st     <= SV_MWR;
                end else begin
                  cnt <= cnt - 1'b1;
                end
              end
              PH_CKS:  ph <= PH_OP;
              default: ph <= PH_OP;
            endcase
          end
        end
        default: st <= SV_IDLE;
      endcase
    end
  end

  always_comb begin
    rm_rd     = (st == SV_FETCH);
    rm_addr   = (ph == PH_DATA) ? src : ip;
    mem_req   = (st == SV_MWR);
    mem_addr  = ptr;
    mem_wdata = byte_q;
    active    = (st != SV_IDLE);
    fin       = fin_q;
  end

endmodule

// File: rtl/nvm_seq_load.sv
module nvm_seq_load
  import nvm_seq_pkg::*;
#(
  parameter int MAW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cond,
  output logic             mem_req,
  output logic [MAW-1:0]   mem_addr,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             rm_wr,
  output logic [RM_AW-1:0] rm_addr,
  output logic [7:0]       rm_wdata,
  output logic             active,
  output logic             fin,
  output logic             upd,
  output logic             err
);

  typedef enum logic [1:0] {LD_IDLE, LD_MRD, LD_APPLY} ld_st_t;

  ld_st_t           st;
  phase_t           ph;
  logic [MAW-1:0]   ptr;
  logic [7:0]       op;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] widx;
  logic [RM_AW-1:0] dst;
  logic [7:0]       sum;
  logic [3:0]       run_no;
  logic             err_q;
  logic             upd_q;
  logic             fin_q;
  logic             buf_we;
  logic [7:0]       run_buf [RUN_MAX];

  assign buf_we = (st == LD_MRD) && (ph == PH_DATA) && mem_ack;

  always_ff @(posedge clk) begin
    if (buf_we) run_buf[idx] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LD_IDLE;
      ph     <= PH_OP;
      ptr    <= '0;
      op     <= '0;
      cnt    <= '0;
      idx    <= '0;
      widx   <= '0;
      dst    <= '0;
      sum    <= '0;
      run_no <= '0;
      err_q  <= 1'b0;
      upd_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      fin_q <= 1'b0;
      case (st)
        LD_IDLE: begin
          if (start) begin
            ptr    <= '0;
            ph     <= PH_OP;
            run_no <= '0;
            err_q  <= 1'b0;
            st     <= LD_MRD;
          end
        end
        LD_MRD: begin
          if (mem_ack) begin
            ptr <= ptr + 1'b1;
            case (ph)
              PH_OP: begin
                op <= mem_rdata;
                if (mem_rdata == OP_END) begin
                  st    <= LD_IDLE;
                  fin_q <= 1'b1;
                end else if (mem_rdata == OP_UPDATE) begin
                  upd_q <= 1'b1;
                end else if (is_data_op(mem_rdata)) begin
                  ph <= PH_AHI;
                end
              end
              PH_AHI: begin
                dst <= {mem_rdata, dst[7:0]};
                ph  <= PH_ALO;
              end
              PH_ALO: begin
                dst <= {dst[15:8], mem_rdata};
                ph  <= PH_DATA;
                cnt <= op[LEN_W-1:0];
                idx <= '0;
                sum <= 8'd0;
              end
              PH_DATA: begin
                sum <= sum_add(sum, mem_rdata);
                idx <= idx + 1'b1;
                if (cnt == '0) ph <= PH_CKS;
                else           cnt <= cnt - 1'b1;
              end
              PH_CKS: begin
                ph     <= PH_OP;
                run_no <= run_no + {3'd0, (run_no != 4'hF)};
                if (!cks_good(sum, mem_rdata)) begin
                  err_q <= 1'b1;
                end else if (run_allowed(cond, run_no)) begin
                  st   <= LD_APPLY;
                  widx <= '0;
                end
              end
              default: ph <= PH_OP;
            endcase
          end
        end
        LD_APPLY: begin
          widx <= widx + 1'b1;
          if (widx == op[LEN_W-1:0]) st <= LD_MRD;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (st == LD_MRD);
    mem_addr = ptr;
    rm_wr    = (st == LD_APPLY);
    rm_addr  = dst + {{(RM_AW-LEN_W){1'b0}}, widx};
    rm_wdata = run_buf[widx];
    active   = (st != LD_IDLE);
    fin      = fin_q;
    upd      = upd_q;
    err      = err_q;
  end

endmodule

// File: rtl/nvm_image_seq.sv
module nvm_image_seq
  import nvm_seq_pkg::*;
#(
  parameter int          MAW       = 12,
  parameter logic [15:0] LIST_BASE = 16'h0E10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_wen,
  input  logic [3:0]       ctl_cond,
  input  logic             save_go,
  input  logic             load_go,
  output logic             rm_rd,
  output logic             rm_wr,
  output logic [RM_AW-1:0] rm_addr,
  output logic [7:0]       rm_wdata,
  input  logic [7:0]       rm_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [MAW-1:0]   mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             upd_pulse,
  output logic             cks_err
);

  logic             wen_q;
  logic [3:0]       cond_q;
  logic             start_save;
  logic             start_load;
  logic             save_active;
  logic             load_active;
  logic             save_fin;
  logic             load_fin;
  logic             sv_mem_req;
  logic [MAW-1:0]   sv_mem_addr;
  logic             ld_mem_req;
  logic [MAW-1:0]   ld_mem_addr;
  logic [RM_AW-1:0] sv_rm_addr;
  logic [RM_AW-1:0] ld_rm_addr;

  nvm_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wen    (ctl_wen),
    .ctl_cond   (ctl_cond),
    .save_go    (save_go),
    .load_go    (load_go),
    .busy       (busy),
    .wen_q      (wen_q),
    .cond_q     (cond_q),
    .start_save (start_save),
    .start_load (start_load)
  );

  nvm_seq_save #(.MAW(MAW), .LIST_BASE(LIST_BASE)) u_save (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_save),
    .rm_rd     (rm_rd),
    .rm_addr   (sv_rm_addr),
    .rm_rdata  (rm_rdata),
    .mem_req   (sv_mem_req),
    .mem_addr  (sv_mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .active    (save_active),
    .fin       (save_fin)
  );

  nvm_seq_load #(.MAW(MAW)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_load),
    .cond      (cond_q),
    .mem_req   (ld_mem_req),
    .mem_addr  (ld_mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .rm_wr     (rm_wr),
    .rm_addr   (ld_rm_addr),
    .rm_wdata  (rm_wdata),
    .active    (load_active),
    .fin       (load_fin),
    .upd       (upd_pulse),
    .err       (cks_err)
  );

  always_comb begin
    busy     = save_active || load_active;
    done     = save_fin || load_fin;
    mem_req  = sv_mem_req || ld_mem_req;
    mem_we   = save_active;
    mem_addr = save_active ? sv_mem_addr : ld_mem_addr;
    rm_addr  = save_active ? sv_rm_addr : ld_rm_addr;
  end

endmodule

// File: rtl/nvm_image_seq_chk.sv
module nvm_image_seq_chk #(
  parameter int MAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           save_go,
  input logic           load_go,
  input logic           wen_q,
  input logic           start_load,
  input logic           save_active,
  input logic           load_active,
  input logic           rm_rd,
  input logic           rm_wr,
  input logic           mem_req,
  input logic           mem_we,
  input logic [MAW-1:0] mem_addr,
  input logic [7:0]     mem_wdata,
  input logic           mem_ack,
  input logic           busy,
  input logic           done,
  input logic           upd_pulse,
  input logic           cks_err
);

  // R2
  save_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_go && !load_go && !wen_q && !busy |=> !busy);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

  // R11
  one_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_active && load_active));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  upd_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> load_active && !mem_req || load_active);

  // R8
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cks_err && !start_load |=> cks_err);

  // R7
  map_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_wr |-> load_active && !rm_rd);

endmodule

bind nvm_image_seq nvm_image_seq_chk #(.MAW(MAW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_go     (save_go),
  .load_go     (load_go),
  .wen_q       (wen_q),
  .start_load  (start_load),
  .save_active (save_active),
  .load_active (load_active),
  .rm_rd       (rm_rd),
  .rm_wr       (rm_wr),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .busy        (busy),
  .done        (done),
  .upd_pulse   (upd_pulse),
  .cks_err     (cks_err)
);

// File: tb/nvm_image_seq_bench.sv
module nvm_image_seq_bench;

  localparam int MAW = 12;
  localparam int BASE = 16'h0E10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_wen = 1'b0;
  logic [3:0] ctl_cond = 4'd0;
  logic save_go = 1'b0, load_go = 1'b0;
  logic rm_rd, rm_wr;
  logic [15:0] rm_addr;
  logic [7:0] rm_wdata;
  logic [7:0] rm_rdata = 8'd0;
  logic mem_req, mem_we;
  logic [MAW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = 8'd0;
  logic busy, done, upd_pulse, cks_err;

  always #5 clk = ~clk;

  nvm_image_seq u_nvm_image_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wen(ctl_wen), .ctl_cond(ctl_cond),
    .save_go(save_go), .load_go(load_go), .rm_rd(rm_rd), .rm_wr(rm_wr),
    .rm_addr(rm_addr), .rm_wdata(rm_wdata), .rm_rdata(rm_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .upd_pulse(upd_pulse), .cks_err(cks_err)
  );

  logic [7:0] rm  [0:65535];
  logic [7:0] mem [0:(1<<MAW)-1];
  int nwr = 0;
  logic tb_rm_we = 1'b0, tb_mem_we = 1'b0;
  logic [15:0] tb_a = 16'd0;
  logic [7:0] tb_d = 8'd0;

  always @(posedge clk) begin
    if (tb_rm_we) rm[tb_a] <= tb_d;
    else if (rm_wr) rm[rm_addr] <= rm_wdata;
    if (rm_rd) rm_rdata <= rm[rm_addr];
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (tb_mem_we) mem[tb_a[MAW-1:0]] <= tb_d;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr];
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr <= nwr + 1;
      end
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic rm_poke(input int a, input int d);
    @(negedge clk);
    tb_rm_we = 1'b1; tb_a = 16'(a); tb_d = 8'(d);
    @(negedge clk);
    tb_rm_we = 1'b0;
  endtask

  task automatic mem_poke(input int a, input int d);
    @(negedge clk);
    tb_mem_we = 1'b1; tb_a = 16'(a); tb_d = 8'(d);
    @(negedge clk);
    tb_mem_we = 1'b0;
  endtask

  task automatic set_ctl(input bit w, input int c);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wen = w; ctl_cond = 4'(c);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse(input bit is_save);
    @(negedge clk);
    if (is_save) save_go = 1'b1; else load_go = 1'b1;
    @(negedge clk);
    save_go = 1'b0; load_go = 1'b0;
  endtask

  task automatic wait_done(output int dn, output int up);
    dn = 0; up = 0;
    for (int n = 0; n < 20000; n++) begin
      if (done) dn++;
      if (upd_pulse) up++;
      if (dn > 0 && !done && !busy) break;
      @(negedge clk);
    end
  endtask

  int exp_img [0:4095];
  int exp_len;

  task automatic build_expect();
    int i, b, a, s;
    i = BASE; exp_len = 0;
    for (int guard = 0; guard < 64; guard++) begin
      b = int'(rm[i]);
      if (b < 128) begin
        exp_img[exp_len] = b; exp_img[exp_len+1] = int'(rm[i+1]); exp_img[exp_len+2] = int'(rm[i+2]);
        a = int'(rm[i+1]) * 256 + int'(rm[i+2]);
        exp_len += 3; s = 0;
        for (int k = 0; k <= b; k++) begin
          exp_img[exp_len] = int'(rm[(a + k) % 65536]);
          s += exp_img[exp_len];
          exp_len++;
        end
        exp_img[exp_len] = (256 - (s % 256)) % 256;
        exp_len++;
        i += 3;
      end else if (b == 128) begin
        exp_img[exp_len] = b; exp_len++; i++;
      end else if (b == 255) begin
        exp_img[exp_len] = b; exp_len++;
        break;
      end else begin
        i++;
      end
    end
  endtask

  task automatic save_and_compare(input string tag);
    int w0, dn, up, bad;
    w0 = nwr;
    build_expect();
    pulse(1'b1);
    wait_done(dn, up);
    chk(dn == 1, {tag, " R5 done width"}, dn, 1);
    chk(nwr - w0 == exp_len, {tag, " R3 write count"}, nwr - w0, exp_len);
    bad = 0;
    for (int i = 0; i < exp_len; i++) if (int'(mem[i]) != exp_img[i]) bad++;
    chk(bad == 0, {tag, " R3 image bytes"}, bad, 0);
  endtask

  function automatic int pat(input int a, input int seed);
    return (a * 7 + seed * 13 + 3) % 256;
  endfunction

  task automatic fill(input int a, input int n, input int seed, input bit inv);
    for (int k = 0; k < n; k++) rm_poke(a + k, inv ? (pat(a + k, seed) ^ 8'h5A) : pat(a + k, seed));
  endtask

  function automatic int region_bad(input int a, input int n, input int seed, input bit inv);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++)
      if (int'(rm[a + k]) != (inv ? (pat(a + k, seed) ^ 8'h5A) : pat(a + k, seed))) bad++;
    return bad;
  endfunction

  task automatic put_default_list();
    int lst [8] = '{8'h01, 8'h00, 8'h06, 8'h08, 8'h01, 8'h00, 8'h80, 8'hFF};
    for (int k = 0; k < 8; k++) rm_poke(BASE + k, lst[k]);
  endtask

  initial begin
    int dn, up, w0, s, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!cks_err && !upd_pulse, "R1 err/upd", {cks_err, upd_pulse}, 0);
    chk(!mem_req && !rm_wr, "R1 mem_req/rm_wr", {mem_req, rm_wr}, 0);

    put_default_list();
    fill(16'h0006, 2, 1, 0);
    fill(16'h0100, 9, 2, 0);

    // R2 save while protected (reset value of write-enable)
    w0 = nwr; bad = 0;
    pulse(1'b1);
    for (int n = 0; n < 20; n++) begin if (busy) bad++; @(negedge clk); end
    chk(bad == 0, "R2 busy while protected", bad, 0);
    chk(nwr == w0, "R2 writes while protected", nwr - w0, 0);

    set_ctl(1'b1, 0);
    save_and_compare("default");
    chk(exp_len == 21, "R3 default image length", exp_len, 21);
    chk(!busy, "R5 idle after end", busy, 0);
    s = int'(mem[3]) + int'(mem[4]) + int'(mem[5]);
    chk(s % 256 == 0, "R4 run1 checksum", s % 256, 0);
    s = 0;
    for (int k = 9; k <= 18; k++) s += int'(mem[k]);
    chk(s % 256 == 0, "R4 run2 checksum", s % 256, 0);
    chk(mem[19] == 8'h80 && mem[20] == 8'hFF, "R5 update and end bytes", int'(mem[19]), 128);

    // R7 R8 load default image back
    fill(16'h0006, 2, 1, 1);
    fill(16'h0100, 9, 2, 1);
    pulse(1'b0);
    wait_done(dn, up);
    chk(region_bad(16'h0006, 2, 1, 0) == 0, "R7 run1 restored", region_bad(16'h0006, 2, 1, 0), 0);
    chk(region_bad(16'h0100, 9, 2, 0) == 0, "R7 run2 restored", region_bad(16'h0100, 9, 2, 0), 0);
    chk(up == 1, "R8 update pulse count", up, 1);
    chk(!cks_err, "R9 no error on clean image", cks_err, 0);

    // R10 condition sweep
    for (int c = 0; c < 4; c++) begin
      set_ctl(1'b1, c);
      fill(16'h0006, 2, 1, 1);
      fill(16'h0100, 9, 2, 1);
      pulse(1'b0);
      wait_done(dn, up);
      chk(region_bad(16'h0006, 2, 1, (c != 0 && c < 1)) == 0, "R10 run1 gating", c, 1);
      chk(region_bad(16'h0100, 9, 2, (c != 0 && c < 2)) == 0, "R10 run2 gating", c, 2);
    end
    set_ctl(1'b1, 0);

    // R9 corrupt run1 checksum
    mem_poke(5, int'(mem[5]) ^ 1);
    fill(16'h0006, 2, 1, 1);
    fill(16'h0100, 9, 2, 1);
    pulse(1'b0);
    wait_done(dn, up);
    chk(cks_err, "R9 sticky error set", cks_err, 1);
    chk(region_bad(16'h0006, 2, 1, 1) == 0, "R9 bad run not applied", region_bad(16'h0006, 2, 1, 1), 0);
    chk(region_bad(16'h0100, 9, 2, 0) == 0, "R9 later run applied", region_bad(16'h0100, 9, 2, 0), 0);
    mem_poke(5, int'(mem[5]) ^ 1);
    pulse(1'b0);
    wait_done(dn, up);
    chk(!cks_err, "R9 error cleared by new load", cks_err, 0);

    // R11 save pulse during load is ignored
    w0 = nwr;
    @(negedge clk); load_go = 1'b1;
    @(negedge clk); load_go = 1'b0;
    repeat (3) @(negedge clk);
    save_go = 1'b1;
    @(negedge clk); save_go = 1'b0;
    wait_done(dn, up);
    chk(nwr == w0, "R11 save ignored while busy", nwr - w0, 0);

    // R6 skipped codes in the list
    begin
      int lst [8] = '{8'h90, 8'h02, 8'h12, 8'h34, 8'hC5, 8'h80, 8'hFE, 8'hFF};
      for (int k = 0; k < 8; k++) rm_poke(BASE + k, lst[k]);
      fill(16'h1234, 3, 5, 0);
      save_and_compare("R6 skip list");
      chk(exp_len == 9, "R6 image length", exp_len, 9);
    end

    // R3 R7 sweep of run lengths
    for (int n = 0; n <= 32; n++) begin
      int len;
      len = (n == 32) ? 127 : n;
      rm_poke(BASE, len); rm_poke(BASE + 1, 8'h20); rm_poke(BASE + 2, 8'h00); rm_poke(BASE + 3, 8'hFF);
      fill(16'h2000, len + 1, n, 0);
      save_and_compare("R3 sweep");
      fill(16'h2000, len + 1, n, 1);
      pulse(1'b0);
      wait_done(dn, up);
      bad = region_bad(16'h2000, len + 1, n, 0);
      chk(bad == 0, "R7 sweep restore", bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule